// File: doc/BRIEF.md
# In-Order Pipeline Interlock Unit

This block is the stall and squash controller for an in-order pipeline that has no operand forwarding. Instructions move through two fetch stages and a decode stage. Decode reads the register files in the second half of its cycle. It then issues each instruction to one of two execute paths: a one-stage integer path, used by ALU operations, loads, stores and branches, or a three-stage path used by FP add/subtract and by every multiply. Both paths continue through a two-stage data memory into a write-back stage. Write-back updates the register file in the first half of its cycle.

The unit keeps a scoreboard ordered by time until write-back. Each issued instruction occupies the slot that matches the number of cycles left before it writes back. A slot records whether the instruction writes a register, which file that register is in, and its index. The slots move one step closer to write-back every cycle. From this scoreboard, the unit holds the fetch and decode stages and sends a no-op into execute in three cases: a source is still pending, an older write to the same destination would land later, or two instructions would reach memory and write-back in the same cycle. A taken branch reported by the integer execute stage squashes the front end. The instruction that sits in decode during that cycle is dropped and never tracked.

Top module: `ilk_interlock`

## Requirements
- R1: After reset the scoreboard is empty. With `d_valid` low, `front_hold`, `front_squash` and `d_issue` are 0 and `ex_nop` is 1. The first instruction presented issues in the same cycle, whatever its sources are.
- R2: A producer on the integer path (`d_fp_path`=0), such as an ALU op or a load, makes a dependent instruction that reaches decode in the next cycle wait exactly 3 held cycles. The dependent instruction issues in the producer's write-back cycle.
- R3: A producer on the FP/multiply path (`d_fp_path`=1) makes a dependent instruction that reaches decode in the next cycle wait exactly 5 held cycles.
- R4: Integer register 0 (file bit `*_fp`=0, index 0) never causes a hold, either as a source or as a destination. FP register 0 (file bit 1, index 0) is tracked like any other register.
- R5: No two instructions reach memory and write-back in the same cycle. An integer-path instruction is held for one cycle when an FP-path instruction issued two cycles before it.
- R6: An instruction is held while an older in-flight instruction with the same destination register would write back in the same cycle as it or later. It issues once its own write-back falls strictly after that older write.
- R7: While an instruction is held, `front_hold`=1, `d_issue`=0 and `ex_nop`=1. `front_hold` is only ever asserted when `d_valid` is 1.
- R8: In a cycle with `ex_br_taken`=1, `front_squash`=1, and both `d_issue` and `front_hold` are 0, even if the decode instruction has a hazard. The squashed instruction leaves nothing in the scoreboard, so a later reader of its destination is not held.
- R9: Both source operands are checked, and so is the data operand of a store. A store whose data comes from a preceding load waits 3 held cycles.
- R10: In a mixed stream, each instruction issues in the earliest cycle that meets R2 to R6. No instruction is held longer than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_valid | input | 1 | Decode holds an instruction |
| d_fp_path | input | 1 | 1: instruction uses the FP/multiply path, 0: integer path |
| d_src_a_en | input | 1 | Source A is read |
| d_src_a_fp | input | 1 | Source A file (1 = FP) |
| d_src_a_idx | input | 5 | Source A register index |
| d_src_b_en | input | 1 | Source B is read (store data uses this port) |
| d_src_b_fp | input | 1 | Source B file (1 = FP) |
| d_src_b_idx | input | 5 | Source B register index |
| d_dst_en | input | 1 | Instruction writes a register |
| d_dst_fp | input | 1 | Destination file (1 = FP) |
| d_dst_idx | input | 5 | Destination register index |
| ex_br_taken | input | 1 | Branch in integer execute is taken this cycle |
| front_hold | output | 1 | Hold both fetch stages and decode |
| ex_nop | output | 1 | Execute receives a no-op this cycle |
| front_squash | output | 1 | Kill fetch and decode contents |
| d_issue | output | 1 | Decode instruction leaves for execute this cycle |

## Verification
The bench targets the exact hold counts. A design that is off by one in slot timing, or that ignores the split-cycle register file, would wait 2 or 4 cycles instead of 3 after an integer producer, and 4 or 6 instead of 5 after an FP producer. It also checks the integer-versus-FP register 0 distinction, where a design would either stall on the hardwired zero or miss a real dependency on FP register 0. The structural and write-after-write cases catch a design that lets an integer op collide with an earlier FP op in memory, or lets an older FP write overwrite a younger result. The branch case checks that a squashed decode instruction is neither held nor left behind as a phantom producer. A long mixed stream is compared against a timestamp model, which exposes any extra stall.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  parameter int unsigned ILK_REG_W = 5;

  typedef struct packed {
    logic                 valid;
    logic                 wr;
    logic                 fp;
    logic [ILK_REG_W-1:0] idx;
  } sb_ent_t;

  // A register operand matters unless it is disabled or the integer zero register.
  function automatic logic operand_live(input logic en, input logic fp,
                                        input logic [ILK_REG_W-1:0] idx);
    return en && (fp || (idx != '0));
  endfunction

  function automatic logic reg_match(input sb_ent_t e, input logic fp,
                                     input logic [ILK_REG_W-1:0] idx);
    return e.valid && e.wr && (e.fp == fp) && (e.idx == idx);
  endfunction

  // Cycles from the first cycle after issue until write-back.
  function automatic int unsigned path_latency(input int unsigned ex_stages,
                                               input int unsigned mem_stages);
    return ex_stages + mem_stages;
  endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
  import ilk_pkg::*;
#(
  parameter int unsigned INT_LAT = 3,
  parameter int unsigned FP_LAT  = 5,
  parameter int unsigned DEPTH   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_en,
  input  logic                ins_fp_path,
  input  sb_ent_t             ins_ent,
  output sb_ent_t [DEPTH:1]   ent_q
);

  sb_ent_t [DEPTH:1] shifted;
  sb_ent_t [DEPTH:1] nxt;
  logic              collide;

  generate
    for (genvar k = 1; k <= DEPTH; k++) begin : g_shift
      if (k < DEPTH) begin : g_mid
        assign shifted[k] = ent_q[k+1];
      end else begin : g_top
        assign shifted[k] = '0;
      end
    end
  endgenerate

  always_comb begin
    nxt = shifted;
    if (ins_en) begin
      if (ins_fp_path) nxt[FP_LAT]  = ins_ent;
      else             nxt[INT_LAT] = ins_ent;
    end
  end

  assign collide = ins_en && (ins_fp_path ? shifted[FP_LAT].valid
                                          : shifted[INT_LAT].valid);

  always_ff @(posedge clk) begin
    if (!rst_n) ent_q <= '0;
    else        ent_q <= nxt;
  end

  assert_no_wb_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !collide);

  generate
    for (genvar k = 1; k <= DEPTH; k++) begin : g_chk
      assert_zero_untracked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ent_q[k].valid && ent_q[k].wr && !ent_q[k].fp && (ent_q[k].idx == '0)));
      if (k >= 2) begin : g_age
        assert_slot_ages_R2: assert property (@(posedge clk) disable iff (!rst_n)
          ent_q[k].valid |=> ent_q[k-1].valid);
      end
    end
  endgenerate

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int unsigned INT_LAT = 3,
  parameter int unsigned FP_LAT  = 5,
  parameter int unsigned DEPTH   = 5
) (
  input  sb_ent_t [DEPTH:1]     ent,
  input  logic                  fp_path,
  input  logic                  a_en,
  input  logic                  a_fp,
  input  logic [ILK_REG_W-1:0]  a_idx,
  input  logic                  b_en,
  input  logic                  b_fp,
  input  logic [ILK_REG_W-1:0]  b_idx,
  input  logic                  dst_en,
  input  logic                  dst_fp,
  input  logic [ILK_REG_W-1:0]  dst_idx,
  output logic                  raw_stall,
  output logic                  waw_stall,
  output logic                  slot_stall
);

  int   lat_sel;
  logic a_live, b_live, dst_live;

  assign a_live   = operand_live(a_en, a_fp, a_idx);
  assign b_live   = operand_live(b_en, b_fp, b_idx);
  assign dst_live = operand_live(dst_en, dst_fp, dst_idx);

  always_comb begin
    lat_sel    = fp_path ? int'(FP_LAT) : int'(INT_LAT);
    raw_stall  = 1'b0;
    waw_stall  = 1'b0;
    slot_stall = 1'b0;
    for (int k = 1; k <= int'(DEPTH); k++) begin
      // any pending write, however close, blocks a read: no forwarding
      if (a_live && reg_match(ent[k], a_fp, a_idx)) raw_stall = 1'b1;
      if (b_live && reg_match(ent[k], b_fp, b_idx)) raw_stall = 1'b1;
      // entry that lands in our write-back slot after the shift
      if ((k == lat_sel + 1) && ent[k].valid) slot_stall = 1'b1;
      // older write to our destination landing after ours
      if ((k > lat_sel) && dst_live && reg_match(ent[k], dst_fp, dst_idx))
        waw_stall = 1'b1;
    end
  end

endmodule

// File: rtl/ilk_issue_ctrl.sv
module ilk_issue_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic d_valid,
  input  logic raw_stall,
  input  logic waw_stall,
  input  logic slot_stall,
  input  logic br_taken,
  output logic hold,
  output logic issue,
  output logic nop,
  output logic squash
);

  logic any_hazard;

  assign any_hazard = raw_stall || waw_stall || slot_stall;
  assign squash     = br_taken;
  assign hold       = d_valid && any_hazard && !br_taken;
  assign issue      = d_valid && !any_hazard && !br_taken;
  assign nop        = !issue;

  assert_squash_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (!issue && !hold));

  assert_hold_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (d_valid && nop));

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
  import ilk_pkg::*;
#(
  parameter int unsigned INT_EX_STAGES = 1,
  parameter int unsigned FP_EX_STAGES  = 3,
  parameter int unsigned MEM_STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 d_valid,
  input  logic                 d_fp_path,
  input  logic                 d_src_a_en,
  input  logic                 d_src_a_fp,
  input  logic [ILK_REG_W-1:0] d_src_a_idx,
  input  logic                 d_src_b_en,
  input  logic                 d_src_b_fp,
  input  logic [ILK_REG_W-1:0] d_src_b_idx,
  input  logic                 d_dst_en,
  input  logic                 d_dst_fp,
  input  logic [ILK_REG_W-1:0] d_dst_idx,
  input  logic                 ex_br_taken,
  output logic                 front_hold,
  output logic                 ex_nop,
  output logic                 front_squash,
  output logic                 d_issue
);

  localparam int unsigned INT_LAT = path_latency(INT_EX_STAGES, MEM_STAGES);
  localparam int unsigned FP_LAT  = path_latency(FP_EX_STAGES, MEM_STAGES);
  localparam int unsigned DEPTH   = (FP_LAT > INT_LAT) ? FP_LAT : INT_LAT;

  sb_ent_t [DEPTH:1] sb_ent;
  sb_ent_t           new_ent;
  logic              raw_stall, waw_stall, slot_stall;

  always_comb begin
    new_ent       = '0;
    new_ent.valid = 1'b1;
    new_ent.wr    = operand_live(d_dst_en, d_dst_fp, d_dst_idx);
    new_ent.fp    = d_dst_fp;
    new_ent.idx   = d_dst_idx;
  end

  ilk_scoreboard #(.INT_LAT(INT_LAT), .FP_LAT(FP_LAT), .DEPTH(DEPTH)) u_sb (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_en     (d_issue),
    .ins_fp_path(d_fp_path),
    .ins_ent    (new_ent),
    .ent_q      (sb_ent)
  );

  ilk_hazard #(.INT_LAT(INT_LAT), .FP_LAT(FP_LAT), .DEPTH(DEPTH)) u_hz (
    .ent       (sb_ent),
    .fp_path   (d_fp_path),
    .a_en      (d_src_a_en),
    .a_fp      (d_src_a_fp),
    .a_idx     (d_src_a_idx),
    .b_en      (d_src_b_en),
    .b_fp      (d_src_b_fp),
    .b_idx     (d_src_b_idx),
    .dst_en    (d_dst_en),
    .dst_fp    (d_dst_fp),
    .dst_idx   (d_dst_idx),
    .raw_stall (raw_stall),
    .waw_stall (waw_stall),
    .slot_stall(slot_stall)
  );

  ilk_issue_ctrl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_valid   (d_valid),
    .raw_stall (raw_stall),
    .waw_stall (waw_stall),
    .slot_stall(slot_stall),
    .br_taken  (ex_br_taken),
    .hold      (front_hold),
    .issue     (d_issue),
    .nop       (ex_nop),
    .squash    (front_squash)
  );

  assert_int_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (d_issue && !d_fp_path) |=> sb_ent[INT_LAT].valid);

  assert_fp_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_issue && d_fp_path) |=> sb_ent[FP_LAT].valid);

endmodule

// File: tb/ilk_interlock_tb.sv
module ilk_interlock_tb;

  localparam int CLK_PERIOD = 10;
  localparam int INT_WB = 3;   // 1 execute + 2 memory stages
  localparam int FP_WB  = 5;   // 3 execute + 2 memory stages

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       d_valid = 1'b0, d_fp_path = 1'b0;
  logic       d_src_a_en = 1'b0, d_src_a_fp = 1'b0;
  logic [4:0] d_src_a_idx = '0;
  logic       d_src_b_en = 1'b0, d_src_b_fp = 1'b0;
  logic [4:0] d_src_b_idx = '0;
  logic       d_dst_en = 1'b0, d_dst_fp = 1'b0;
  logic [4:0] d_dst_idx = '0;
  logic       ex_br_taken = 1'b0;
  logic       front_hold, ex_nop, front_squash, d_issue;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];
  int    holds = 0;

  int rdy_int[32];
  int rdy_fp[32];
  bit wb_used[0:4095];

  ilk_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_fp_path(d_fp_path),
    .d_src_a_en(d_src_a_en), .d_src_a_fp(d_src_a_fp), .d_src_a_idx(d_src_a_idx),
    .d_src_b_en(d_src_b_en), .d_src_b_fp(d_src_b_fp), .d_src_b_idx(d_src_b_idx),
    .d_dst_en(d_dst_en), .d_dst_fp(d_dst_fp), .d_dst_idx(d_dst_idx),
    .ex_br_taken(ex_br_taken), .front_hold(front_hold), .ex_nop(ex_nop),
    .front_squash(front_squash), .d_issue(d_issue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ready_of(input bit fp, input int idx);
    return fp ? rdy_fp[idx] : rdy_int[idx];
  endfunction

  function automatic bit counts(input bit en, input bit fp, input int idx);
    return en && (fp || idx != 0);
  endfunction

  // Scoreboard monitor: counts held cycles, compares at issue.
  initial begin
    forever begin
      @(negedge clk); #2;
      if (d_valid && front_hold) begin
        holds++;
        check(ex_nop && !d_issue, "R7 hold implies nop", int'(ex_nop), 1);
      end
      if (d_valid && d_issue) begin
        int e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(holds == e && !ex_nop, t, holds, e);
        holds = 0;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      d_valid = 1'b0;
      ex_br_taken = 1'b0;
    end
  endtask

  // hand < 0: expected hold count taken from the timestamp model
  task automatic present(input bit fpp,
                         input bit ae, input bit af, input int ai,
                         input bit be, input bit bf, input int bi,
                         input bit de, input bit df, input int di,
                         input int hand, input string tag);
    int t0, t, wb, lat;
    bit ok;
    @(negedge clk);
    d_valid = 1'b1; d_fp_path = fpp; ex_br_taken = 1'b0;
    d_src_a_en = ae; d_src_a_fp = af; d_src_a_idx = ai[4:0];
    d_src_b_en = be; d_src_b_fp = bf; d_src_b_idx = bi[4:0];
    d_dst_en = de; d_dst_fp = df; d_dst_idx = di[4:0];
    t0 = cyc;
    lat = fpp ? FP_WB : INT_WB;
    t = t0;
    forever begin
      ok = 1'b1;
      if (counts(ae, af, ai) && t < ready_of(af, ai)) ok = 1'b0;
      if (counts(be, bf, bi) && t < ready_of(bf, bi)) ok = 1'b0;
      wb = t + 1 + lat;
      if (wb_used[wb]) ok = 1'b0;
      if (counts(de, df, di) && wb <= ready_of(df, di)) ok = 1'b0;
      if (ok) break;
      t++;
    end
    wb_used[wb] = 1'b1;
    if (counts(de, df, di)) begin
      if (df) rdy_fp[di] = wb; else rdy_int[di] = wb;
    end
    exp_q.push_back(hand >= 0 ? hand : t - t0);
    tag_q.push_back(tag);
    #1;
    while (!d_issue) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 40000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 32; i++) begin rdy_int[i] = 0; rdy_fp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check(!front_hold && !front_squash && !d_issue && ex_nop, "R1 reset outputs",
          {front_hold, front_squash, d_issue, ex_nop}, 1);
    present(0, 1,0,1, 1,1,1, 1,0,1, 0, "R1 first issue immediate");
    present(0, 1,0,1, 0,0,0, 0,0,0, 3, "R2 int add -> branch");
    idle(8);
    present(0, 1,0,3, 0,0,0, 1,0,2, 0, "R2 load");
    present(0, 1,0,2, 1,0,4, 1,0,6, 3, "R2 load -> alu");
    idle(8);
    present(1, 1,1,2, 1,1,3, 1,1,1, 0, "R3 fadd");
    present(1, 1,1,1, 1,1,2, 1,1,5, 5, "R3 fadd -> fadd");
    idle(8);
    present(0, 1,0,4, 0,0,0, 1,1,3, 0, "R9 fp load");
    present(0, 1,0,4, 1,1,3, 0,0,0, 3, "R9 load -> store data");
    idle(8);
    present(1, 1,1,8, 1,1,9, 1,1,0, 0, "R4 fmul f0");
    present(1, 1,1,0, 0,0,0, 1,1,11, 5, "R4 fp reg0 tracked");
    idle(8);
    present(0, 1,0,7, 0,0,0, 1,0,0, 0, "R4 write int reg0");
    present(0, 1,0,0, 1,0,0, 1,0,12, 0, "R4 int reg0 no hold");
    idle(8);
    present(1, 1,1,5, 0,0,0, 1,1,4, 0, "R5 fadd");
    present(0, 0,0,0, 0,0,0, 1,0,9, 0, "R5 int one later");
    present(0, 0,0,0, 0,0,0, 1,0,10, 1, "R5 int two later collides");
    idle(8);
    present(1, 1,1,6, 0,0,0, 1,1,7, 0, "R6 fmul f7");
    present(0, 1,0,3, 0,0,0, 1,1,7, 2, "R6 load f7 waw");
    idle(8);
    // R8: taken branch squashes a hazarded decode instruction
    present(0, 0,0,0, 0,0,0, 1,0,8, 0, "R8 add x8");
    present(0, 0,0,0, 0,0,0, 0,0,0, 0, "R8 branch");
    @(negedge clk);
    d_valid = 1'b1; ex_br_taken = 1'b1; d_fp_path = 1'b0;
    d_src_a_en = 1'b1; d_src_a_fp = 1'b0; d_src_a_idx = 5'd8;
    d_src_b_en = 1'b0; d_dst_en = 1'b1; d_dst_fp = 1'b0; d_dst_idx = 5'd5;
    #1;
    check(front_squash && !d_issue && !front_hold, "R8 squash cycle",
          {front_squash, d_issue, front_hold}, 4);
    idle(2);
    present(0, 1,0,5, 1,0,8, 1,0,13, 0, "R8 squashed dest untracked");
    idle(8);
    // R10: mixed stream against the timestamp model
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      present(lfsr[0], lfsr[1], lfsr[2], int'(lfsr[4:3]),
              lfsr[5], lfsr[6], int'(lfsr[8:7]),
              lfsr[9], lfsr[10], int'(lfsr[12:11]), -1, "R10 mixed stream");
      for (int s = 0; s < 5; s++)
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    idle(4);
    check(exp_q.size() == 0, "R10 all issued", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule